// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a hardware watchdog. A free-running 1 µs strobe from the clock logic feeds a programmable prescaler, and each prescaled tick decrements a 16-bit down-counter. Software programs the divisor and the reload value, sets the enable bit, and must then restart the count at regular intervals. If the count runs out, the block drives a fixed-length reset pulse toward the system reset controller. It also sets a sticky cause flag that the reset it triggered does not clear, so software can find out after boot why the chip restarted.

All access goes through a small 32-bit register port. A request is acknowledged one cycle later with `reg_ready`, and read data is valid in that same cycle. The restart command has its own command register, separate from the control register. This lets software restart the count without a read-modify-write of the control word. The block has two resets. `por_n` clears everything. `sys_rst_n`, which the system asserts in response to the pulse, clears the timer but keeps the cause flag and lets a pulse that has started run to its full length.

Top module: `wdog_timer`

## Requirements
- R1: After `por_n`, the control word reads 0x03E8_0000 (divisor 1000, disabled), the reload word reads 0x0000_FFFF, the cause word reads 0 and `wdt_rst_out` is low.
- R2: The control word sits at offset 0x20. Bit 7 is the enable and reads back as the running state. Bits 31:16 hold the prescaler divisor. All other bits read 0 and are not stored.
- R3: The reload word sits at offset 0x24. Bits 15:0 are stored, and bits 31:16 read 0.
- R4: While the timer is enabled and the base strobe is high on every clock, expiry comes max(reload,1) × max(divisor,1) strobes after the enabling write or the last restart. `wdt_rst_out` rises in the cycle after the strobe that completes the count. With the strobe low, the count does not advance.
- R5: Writing 1 to bit 9 of the command word at offset 0x00 reloads the counter and clears the prescaler phase, which starts a full new period. The command word always reads 0.
- R6: While the timer is disabled, no reset pulse starts. Setting the enable bit again restarts a full period from the reload value.
- R7: Each expiry drives `wdt_rst_out` high for exactly RST_CYCLES (16) consecutive clocks.
- R8: Bit 1 of the cause word at offset 0x04 is set by an expiry. Writing 1 to it clears it, writing 0 leaves it unchanged, and `por_n` clears it.
- R9: `sys_rst_n` returns the control and reload words and the counter to their reset values. It does not clear the cause flag and does not cut short a reset pulse already in progress.
- R10: `reg_ready` follows a request by one cycle, with read data valid in that cycle. Writes to unmapped offsets change nothing, and reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears all state |
| sys_rst_n | input | 1 | System reset, active low, synchronous; clears the timer but not the cause flag or a running pulse |
| base_tick | input | 1 | One-clock strobe every 1 µs, the prescaler input |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid when reg_ready is high |
| reg_ready | output | 1 | Access acknowledge, one cycle after reg_req |
| wdt_rst_out | output | 1 | Reset pulse to the system reset controller |

## Verification
Most internal faults appear at the ports as a shift in the expiry time. A counter or prescaler phase that is off by one moves the rising edge of `wdt_rst_out` by one strobe or by one divisor period. The bench therefore measures that edge to the exact cycle, for several reload and divisor pairs, for zero values, after a restart, and after a disable/enable. Two faults hide until a later event: a cause flag tied to the wrong reset, and a pulse counter that `sys_rst_n` clears. Both are exposed only by applying `sys_rst_n` during a pulse and then checking the pulse length and the cause word.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int ADDR_W      = 8,
  parameter int DIV_W       = 16,
  parameter int CNT_W       = 16,
  parameter int RST_CYCLES  = 16,
  parameter int DEF_DIV     = 1000,
  parameter int DEF_RELOAD  = 65535
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              base_tick,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_ready,
  output logic              wdt_rst_out
);

  localparam int PW = $clog2(RST_CYCLES + 1);
  localparam logic [ADDR_W-1:0] OFS_CMD   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_CAUSE = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_LOAD  = ADDR_W'('h24);
  localparam int EN_BIT    = 7;
  localparam int KICK_BIT  = 9;
  localparam int CAUSE_BIT = 1;
  localparam int DIV_LSB   = 16;

  logic             en_q;
  logic [DIV_W-1:0] div_q, pre_q, div_last;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic [PW-1:0]    pulse_q;
  logic             cause_q;
  logic [31:0]      rd_mux;
  logic             tmr_rst;

  wire wr        = reg_req & reg_we;
  wire wr_cmd    = wr && (reg_addr == OFS_CMD);
  wire wr_cause  = wr && (reg_addr == OFS_CAUSE);
  wire wr_ctrl   = wr && (reg_addr == OFS_CTRL);
  wire wr_load   = wr && (reg_addr == OFS_LOAD);
  wire kick      = wr_cmd & reg_wdata[KICK_BIT];
  wire start     = wr_ctrl & reg_wdata[EN_BIT] & ~en_q;
  wire stop      = wr_ctrl & ~reg_wdata[EN_BIT];

  assign tmr_rst  = ~por_n | ~sys_rst_n;
  assign div_last = (div_q == '0) ? '0 : div_q - 1'b1;

  wire ptick = en_q & base_tick & (pre_q >= div_last);
  wire fire  = ptick & (cnt_q <= CNT_W'(1)) & ~kick & ~stop & sys_rst_n;

  assign wdt_rst_out = (pulse_q != '0);

  always_ff @(posedge clk) begin
    if (tmr_rst) begin
      en_q   <= 1'b0;
      div_q  <= DIV_W'(DEF_DIV);
      load_q <= CNT_W'(DEF_RELOAD);
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[EN_BIT];
        div_q <= reg_wdata[DIV_LSB +: DIV_W];
      end
      if (wr_load) load_q <= reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (tmr_rst) begin
      cnt_q <= CNT_W'(DEF_RELOAD);
      pre_q <= '0;
    end else begin
      if (kick || start || fire)
        cnt_q <= load_q;
      else if (ptick && !stop)
        cnt_q <= cnt_q - 1'b1;

      if (kick || start || stop || ptick)
        pre_q <= '0;
      else if (en_q && base_tick)
        pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      pulse_q <= '0;
      cause_q <= 1'b0;
    end else begin
      if (fire)
        pulse_q <= PW'(RST_CYCLES);
      else if (pulse_q != '0)
        pulse_q <= pulse_q - 1'b1;

      if (fire)
        cause_q <= 1'b1;
      else if (wr_cause && reg_wdata[CAUSE_BIT])
        cause_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_CTRL: begin
        rd_mux[DIV_LSB +: DIV_W] = div_q;
        rd_mux[EN_BIT]           = en_q;
      end
      OFS_LOAD:  rd_mux[CNT_W-1:0] = load_q;
      OFS_CAUSE: rd_mux[CAUSE_BIT] = cause_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tmr_rst) begin
      reg_ready <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ready <= reg_req;
      reg_rdata <= (reg_req && !reg_we) ? rd_mux : '0;
    end
  end

  a_r10_ready_follows: assert property (@(posedge clk) disable iff (tmr_rst)
    reg_req |=> reg_ready);

  a_r8_cause_on_pulse: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wdt_rst_out) |-> cause_q);

  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (tmr_rst)
    (!en_q && !wdt_rst_out) |=> !wdt_rst_out);

  a_r7_pulse_holds: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_rst_out && pulse_q > PW'(1)) |=> wdt_rst_out);

  a_r5_kick_reloads: assert property (@(posedge clk) disable iff (tmr_rst)
    kick |=> (cnt_q == $past(load_q)));

  a_r3_load_upper_zero: assert property (@(posedge clk) disable iff (tmr_rst)
    (reg_ready && $past(reg_addr) == OFS_LOAD) |-> ((reg_rdata >> CNT_W) == 32'd0));

endmodule

// File: tb/test_wdog_timer.sv
module test_wdog_timer;
  logic        clk = 0;
  logic        por_n = 0, sys_rst_n = 1, base_tick = 1;
  logic        reg_req = 0, reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        reg_ready, wdt_rst_out;
  int total = 0, fails = 0;

  always #4 clk = ~clk;

  wdog_timer i_wdog_timer (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .base_tick(base_tick),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ready(reg_ready), .wdt_rst_out(wdt_rst_out));

  // {we, addr, wdata, expected read of addr}
  localparam int NV = 7;
  localparam logic [72:0] VEC [0:NV-1] = '{
    {1'b1, 8'h20, 32'hFFFF_FF7F, 32'hFFFF_0000},  // R2 reserved bits dropped
    {1'b0, 8'h20, 32'h0000_0000, 32'hFFFF_0000},  // R2 readback
    {1'b1, 8'h24, 32'hABCD_1234, 32'h0000_1234},  // R3
    {1'b1, 8'h20, 32'h0005_0080, 32'h0005_0080},  // R2 enable reads back
    {1'b1, 8'h20, 32'h0005_0000, 32'h0005_0000},  // R2 disable
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0000_0000},  // R5 command reads 0
    {1'b0, 8'h04, 32'h0000_0000, 32'h0000_0000}   // R8 no cause yet
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_req = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    chk("R10 ready", {31'd0, reg_ready}, 32'd1);
    d = reg_rdata;
    reg_req = 0;
  endtask

  task automatic expiry(input string tag, input int exp);
    int n = 0;
    while (!wdt_rst_out && n < 5000) begin @(negedge clk); n++; end
    chk(tag, n, exp);
  endtask

  task automatic quiet(input string tag, input int cyc);
    int hits = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (wdt_rst_out) hits++; end
    chk(tag, hits, 0);
  endtask

  task automatic settle();
    wr(8'h20, 32'h0001_0000);
    for (int i = 0; i < 20; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int m;
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    chk("R1 rst_out", {31'd0, wdt_rst_out}, 0);
    chk("R10 ready idle", {31'd0, reg_ready}, 0);
    rd(8'h20, d); chk("R1 ctrl", d, 32'h03E8_0000);
    rd(8'h24, d); chk("R1 reload", d, 32'h0000_FFFF);
    rd(8'h04, d); chk("R1 cause", d, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], d);
      chk($sformatf("vec%0d R2/R3/R5/R8", i), d, VEC[i][31:0]);
    end

    // R10 unmapped
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R10 unmapped ctrl", d, 32'h0005_0000);
    rd(8'h24, d); chk("R10 unmapped reload", d, 32'h0000_1234);
    rd(8'h10, d); chk("R10 unmapped read", d, 0);

    // R4 timing
    wr(8'h24, 6); wr(8'h20, 32'h0003_0080); expiry("R4 6x3", 18); settle();
    rd(8'h04, d); chk("R8 cause set", d, 32'h2);
    wr(8'h04, 0); rd(8'h04, d); chk("R8 write0 keeps", d, 32'h2);
    wr(8'h04, 2); rd(8'h04, d); chk("R8 w1c", d, 0);
    wr(8'h24, 0); wr(8'h20, 32'h0001_0080); expiry("R4 reload0", 1); settle();
    wr(8'h24, 3); wr(8'h20, 32'h0000_0080); expiry("R4 div0", 3); settle();
    wr(8'h24, 2); base_tick = 0; wr(8'h20, 32'h0001_0080);
    quiet("R4 no strobe", 30);
    base_tick = 1; expiry("R4 strobe resumes", 2); settle();

    // R5 kick
    wr(8'h24, 10); wr(8'h20, 32'h0001_0080);
    quiet("R5 before kick", 7);
    wr(8'h00, 32'h0000_0200); expiry("R5 after kick", 10); settle();

    // R6 disabled / re-enable
    quiet("R6 disabled", 60);
    wr(8'h24, 5); wr(8'h20, 32'h0001_0080);
    repeat (3) @(negedge clk);
    wr(8'h20, 32'h0001_0000); quiet("R6 stopped", 20);
    wr(8'h20, 32'h0001_0080); expiry("R6 re-enable", 5); settle();

    // R7 pulse length with R9 system reset during pulse
    wr(8'h24, 40); wr(8'h20, 32'h0001_0080); expiry("R7 40", 40);
    sys_rst_n = 0; m = 0;
    while (wdt_rst_out && m < 100) begin
      m++; @(negedge clk);
      if (m == 2) sys_rst_n = 1;
    end
    chk("R7 R9 pulse length", m, 16);
    rd(8'h20, d); chk("R9 ctrl default", d, 32'h03E8_0000);
    rd(8'h24, d); chk("R9 reload default", d, 32'h0000_FFFF);
    rd(8'h04, d); chk("R8 R9 cause survives", d, 32'h2);
    quiet("R9 timer off", 40);

    por_n = 0; @(negedge clk); por_n = 1; @(negedge clk);
    rd(8'h04, d); chk("R8 por clears", d, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule